// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block drives the transmit side of a network DMA engine. On a poll strobe it walks a ring of 32-byte transmit descriptors held in system memory. It uses a single word-wide memory port with a request/acknowledge handshake. For every descriptor that hardware owns, it reads the control word, the packed size word and the buffer address. It then asks an external byte mover to carry the buffer to the MAC, and hands the descriptor back to software. To do that it clears the ownership bit in the control word and writes that word back to the same address.

Segments are chained until a descriptor flagged as the last segment of a frame. At that point the walker pulses a frame-complete strobe, which the surrounding logic turns into its transmit-interrupt and normal-summary status. After each descriptor, the current pointer steps 32 bytes forward, or returns to the ring base when the descriptor carries the wrap flag. The scan stops at the first descriptor that hardware does not own.

A size anomaly raises a one-cycle error pulse, but processing carries on. A poll that arrives during a scan is remembered, and it runs one further scan once the current one ends.

Top module: `txRingWalker`

## Requirements
- R1: After reset the walker is idle: busy, memReq, xferReq, frameDone and errPulse are low, and the current pointer and ring base are 0.
- R2: A scan reads the control word (byte offset 0 of the descriptor) first. If its bit 31 (owned by hardware) is clear, the scan ends with no transfer and no write.
- R3: For an owned descriptor, the walker reads offset 4 (size word) and offset 8 (buffer address). It then holds xferReq, with xferAddr equal to the buffer address and xferLen equal to (size[11:0] + size[27:16]), until xferDone.
- R4: xferLast equals bit 29 of the control word. frameDone pulses for one cycle, the cycle after an xferDone accepted with xferLast high, and never for a segment without bit 29.
- R5: After the transfer, the control word is written back to the address it was read from, with bit 31 cleared and every other bit unchanged.
- R6: After the write-back, the current pointer reloads from the ring base if bit 21 of the control word is set, and otherwise advances by 32. A baseLoad pulse sets both the ring base and the current pointer.
- R7: errPulse pulses for one cycle, on the first cycle of xferReq, when size[11:0] exceeds 2048 or size[27:16] masked to 12 bits is nonzero. The transfer still takes place.
- R8: busy rises in the cycle after a poll strobe accepted while idle. It stays high until the cycle after the unowned control word that ends the scan.
- R9: Poll strobes that arrive while busy are latched as one, and they start exactly one more scan when the current scan ends.
- R10: memReq, memWe and memAddr hold stable until memAck. memReq and xferReq are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollStrobe | input | 1 | Transmit poll demand |
| baseLoad | input | 1 | Load ring base and current pointer |
| baseAddr | input | 32 | Ring base address |
| memReq | output | 1 | Memory word request |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 32 | Memory word byte address |
| memWdata | output | 32 | Write-back data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Memory access complete |
| xferReq | output | 1 | Buffer transfer request |
| xferAddr | output | 32 | Buffer start address |
| xferLen | output | 13 | Transfer length in bytes |
| xferLast | output | 1 | Segment ends a frame |
| xferDone | input | 1 | Transfer complete |
| busy | output | 1 | Scan in progress |
| frameDone | output | 1 | Frame-complete pulse |
| errPulse | output | 1 | Size anomaly pulse |

## Verification
busy is due one cycle after the poll strobe edge. errPulse is due one cycle after the acknowledge of the buffer-address read. frameDone is due one cycle after an accepted last-segment xferDone. The bench counts these pulses in monitors at the clock edge and checks the counts only once busy has fallen, which is itself one cycle after the terminating control read. The exact one-cycle relations of busy and frameDone are held by clocked properties. Pointer movement is observed from the sequence of control-word addresses the walker issues on the memory port, and write-back from the memory model's contents.

// File: rtl/txwalk_pkg.sv
package txwalk_pkg;
  localparam int OWN_BIT  = 31;
  localparam int LAST_BIT = 29;
  localparam int WRAP_BIT = 21;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTL, ST_SIZE, ST_BUF, ST_XFER, ST_WB
  } walkState_t;

  typedef struct packed {
    logic capCtl;
    logic capSize;
    logic capAddr;
    logic advance;
  } walkStrobe_t;
endpackage

// File: rtl/txwalk_datapath.sv
module txwalk_datapath
  import txwalk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 32,
  parameter int LEN_W      = 12,
  parameter int LEN_LIMIT  = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkStrobe_t       strobe,
  input  logic              baseLoad,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [1:0]        wordSel,
  input  logic [31:0]       memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic              ownNow,
  output logic              lastSeg,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [LEN_W:0]    xferLen,
  output logic              anomaly
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [ADDR_W-1:0] curPtr, basePtr, bufAddr;
  logic [31:0]       ctlWord;
  logic [LEN_W-1:0]  len1, len2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPtr  <= '0;
      basePtr <= '0;
      ctlWord <= '0;
      len1    <= '0;
      len2    <= '0;
      bufAddr <= '0;
    end else begin
      if (strobe.capCtl)  ctlWord <= memRdata;
      if (strobe.capSize) begin
        len1 <= memRdata[LEN_W-1:0];
        len2 <= memRdata[16 +: LEN_W];
      end
      if (strobe.capAddr) bufAddr <= memRdata[ADDR_W-1:0];
      if (baseLoad) begin
        basePtr <= baseAddr;
        curPtr  <= baseAddr;
      end else if (strobe.advance) begin
        curPtr <= ctlWord[WRAP_BIT] ? basePtr : curPtr + STEP;
      end
    end
  end

  always_comb begin
    memAddr  = curPtr + (ADDR_W'(wordSel) << 2);
    memWdata = ctlWord & ~(32'd1 << OWN_BIT);
    ownNow   = memRdata[OWN_BIT];
    lastSeg  = ctlWord[LAST_BIT];
    xferAddr = bufAddr;
    xferLen  = {1'b0, len1} + {1'b0, len2};
    anomaly  = (32'(len1) > 32'(LEN_LIMIT)) || (len2 != '0);
  end
endmodule

// File: rtl/txwalk_control.sv
module txwalk_control
  import txwalk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pollStrobe,
  input  logic        memAck,
  input  logic        ownNow,
  input  logic        lastSeg,
  input  logic        anomaly,
  input  logic        xferDone,
  output walkStrobe_t strobe,
  output logic [1:0]  wordSel,
  output logic        memReq,
  output logic        memWe,
  output logic        xferReq,
  output logic        busy,
  output logic        frameDone,
  output logic        errPulse
);
  walkState_t state, nxt;
  logic pendQ, consume, frameSet, errSet;

  always_comb begin
    nxt      = state;
    strobe   = '0;
    wordSel  = 2'd0;
    memReq   = 1'b0;
    memWe    = 1'b0;
    xferReq  = 1'b0;
    consume  = 1'b0;
    frameSet = 1'b0;
    errSet   = 1'b0;
    unique case (state)
      ST_IDLE: if (pollStrobe || pendQ) begin
        nxt     = ST_CTL;
        consume = 1'b1;
      end
      ST_CTL: begin
        memReq = 1'b1;
        if (memAck) begin
          strobe.capCtl = 1'b1;
          if (ownNow) nxt = ST_SIZE;
          else if (pendQ || pollStrobe) consume = 1'b1;
          else nxt = ST_IDLE;
        end
      end
      ST_SIZE: begin
        memReq  = 1'b1;
        wordSel = 2'd1;
        if (memAck) begin
          strobe.capSize = 1'b1;
          nxt = ST_BUF;
        end
      end
      ST_BUF: begin
        memReq  = 1'b1;
        wordSel = 2'd2;
        if (memAck) begin
          strobe.capAddr = 1'b1;
          errSet = anomaly;
          nxt = ST_XFER;
        end
      end
      ST_XFER: begin
        xferReq = 1'b1;
        if (xferDone) begin
          frameSet = lastSeg;
          nxt = ST_WB;
        end
      end
      ST_WB: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strobe.advance = 1'b1;
          nxt = ST_CTL;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pendQ     <= 1'b0;
      frameDone <= 1'b0;
      errPulse  <= 1'b0;
    end else begin
      state     <= nxt;
      pendQ     <= (pendQ || (pollStrobe && state != ST_IDLE)) && !consume;
      frameDone <= frameSet;
      errPulse  <= errSet;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/txRingWalker.sv
module txRingWalker
  import txwalk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 32,
  parameter int LEN_W      = 12,
  parameter int LEN_LIMIT  = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pollStrobe,
  input  logic              baseLoad,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memAck,
  output logic              xferReq,
  output logic [ADDR_W-1:0] xferAddr,
  output logic [LEN_W:0]    xferLen,
  output logic              xferLast,
  input  logic              xferDone,
  output logic              busy,
  output logic              frameDone,
  output logic              errPulse
);
  walkStrobe_t strobe;
  logic [1:0]  wordSel;
  logic        ownNow, lastSeg, anomaly;

  txwalk_control u_ctl (
    .clk, .rstN, .pollStrobe, .memAck, .ownNow, .lastSeg, .anomaly,
    .xferDone, .strobe, .wordSel, .memReq, .memWe, .xferReq, .busy,
    .frameDone, .errPulse
  );

  txwalk_datapath #(
    .ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES), .LEN_W(LEN_W), .LEN_LIMIT(LEN_LIMIT)
  ) u_dp (
    .clk, .rstN, .strobe, .baseLoad, .baseAddr, .wordSel, .memRdata,
    .memAddr, .memWdata, .ownNow, .lastSeg, .xferAddr, .xferLen, .anomaly
  );

  assign xferLast = lastSeg;
endmodule

// File: rtl/txRingWalker_chk.sv
module txRingWalker_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              pollStrobe,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWdata,
  input logic              memAck,
  input logic              xferReq,
  input logic [LEN_W:0]    xferLen,
  input logic              xferLast,
  input logic              xferDone,
  input logic              busy,
  input logic              frameDone
);
  AST_WB_OWN_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe |-> !memWdata[31]); // R5
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe)); // R10
  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memReq && xferReq)); // R10
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    xferReq && !xferDone |=> xferReq && $stable(xferLen)); // R3
  AST_FRAME_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> $past(xferReq && xferDone && xferLast)); // R4
  AST_BUSY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !busy && pollStrobe |=> busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq && !xferReq); // R8
endmodule

bind txRingWalker txRingWalker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk, .rstN, .pollStrobe, .memReq, .memWe, .memAddr, .memWdata, .memAck,
  .xferReq, .xferLen, .xferLast, .xferDone, .busy, .frameDone
);

// File: tb/txRingWalker_test.sv
module txRingWalker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pollStrobe = 1'b0, baseLoad = 1'b0;
  logic [31:0] baseAddr = '0;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic        xferReq, xferLast, xferDone, busy, frameDone, errPulse;
  logic [31:0] xferAddr;
  logic [12:0] xferLen;

  always #5 clk = ~clk;

  txRingWalker uut (
    .clk, .rstN, .pollStrobe, .baseLoad, .baseAddr, .memReq, .memWe, .memAddr,
    .memWdata, .memRdata, .memAck, .xferReq, .xferAddr, .xferLen, .xferLast,
    .xferDone, .busy, .frameDone, .errPulse
  );

  logic [31:0] mem [64];
  int nChk = 0, nFail = 0;
  int nLog, xferCnt, frameCnt, errCnt, wbCnt, lastLen, lastAddr, lastFlag, xcnt;
  int ctlLog [16];

  // memory model: one-cycle acknowledge, data with acknowledge
  always @(posedge clk) begin
    if (!rstN) begin
      memAck <= 1'b0;
      memRdata <= '0;
    end else begin
      memAck <= memReq && !memAck;
      memRdata <= mem[memAddr[7:2]];
      if (memReq && memAck && memWe) begin
        mem[memAddr[7:2]] <= memWdata;
        wbCnt <= wbCnt + 1;
      end
      if (memReq && memAck && !memWe && memAddr[4:0] == 5'd0 && nLog < 16) begin
        ctlLog[nLog] <= int'(memAddr);
        nLog <= nLog + 1;
      end
    end
  end

  // byte mover model and pulse monitors
  always @(posedge clk) begin
    if (!rstN) begin
      xferDone <= 1'b0;
      xcnt <= 0;
    end else begin
      xferDone <= xferReq && !xferDone && xcnt >= 2;
      xcnt <= (xferReq && !xferDone) ? xcnt + 1 : 0;
      if (xferReq && xferDone) begin
        xferCnt  <= xferCnt + 1;
        lastLen  <= int'(xferLen);
        lastAddr <= int'(xferAddr);
        lastFlag <= int'(xferLast);
      end
      if (frameDone) frameCnt <= frameCnt + 1;
      if (errPulse) errCnt <= errCnt + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic clearAll();
    for (int i = 0; i < 64; i++) mem[i] = '0;
    nLog = 0; xferCnt = 0; frameCnt = 0; errCnt = 0; wbCnt = 0;
    lastLen = 0; lastAddr = 0; lastFlag = 0;
  endtask

  task automatic putDesc(input int byteAddr, input logic [31:0] ctl,
                         input logic [31:0] sizes, input logic [31:0] addr);
    mem[byteAddr/4]     = ctl;
    mem[byteAddr/4 + 1] = sizes;
    mem[byteAddr/4 + 2] = addr;
  endtask

  task automatic loadBase(input logic [31:0] a);
    @(negedge clk); baseAddr = a; baseLoad = 1'b1;
    @(negedge clk); baseLoad = 1'b0;
  endtask

  task automatic pulsePoll(input bit checkBusy);
    @(negedge clk); pollStrobe = 1'b1;
    @(negedge clk); pollStrobe = 1'b0;
    if (checkBusy) check(busy == 1'b1, "R8 busy after poll", int'(busy), 1);
  endtask

  task automatic waitIdle();
    int t = 0;
    while (busy && t < 2000) begin
      @(negedge clk); t++;
    end
    repeat (2) @(negedge clk);
  endtask

  localparam logic [31:0] OWN = 32'h8000_0000, LAST = 32'h2000_0000, WRAP = 32'h0020_0000;
  // {control, size1, size2, buffer address}
  localparam logic [95:0] VEC [6] = '{
    {32'hA000_0100, 16'h0064, 16'h0000, 32'h0000_1000},
    {32'h8000_0000, 16'h0040, 16'h0000, 32'h0000_2000},
    {32'hA020_0000, 16'h0800, 16'h0000, 32'h0000_3000},
    {32'hA000_0000, 16'h0801, 16'h0000, 32'h0000_4000},
    {32'hA000_0000, 16'h000A, 16'h0005, 32'h0000_5000},
    {32'hA020_0000, 16'hF0FF, 16'h1003, 32'h0000_6000}
  };

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 100000) begin
        nChk++; nFail++;
        $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
        $finish;
      end
    end
  end

  initial begin
    clearAll();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0, "R1 busy", int'(busy), 0);
    check(memReq == 0 && xferReq == 0, "R1 requests", int'({memReq, xferReq}), 0);
    check(frameDone == 0 && errPulse == 0, "R1 pulses", int'({frameDone, errPulse}), 0);

    // R1/R2: pointer starts at 0, unowned descriptor ends scan
    putDesc(0, 32'h2000_0000, 32'h10, 32'h100);
    pulsePoll(1);
    waitIdle();
    check(nLog == 1 && ctlLog[0] == 0, "R1 first read at 0", ctlLog[0], 0);
    check(xferCnt == 0, "R2 no transfer", xferCnt, 0);
    check(wbCnt == 0, "R2 no write", wbCnt, 0);
    check(busy == 0, "R8 busy fell", int'(busy), 0);

    // table of single-descriptor scans
    for (int i = 0; i < 6; i++) begin
      logic [31:0] ctl, a;
      logic [15:0] s1, s2;
      int e1, e2, isLast, anom, nxt;
      {ctl, s1, s2, a} = VEC[i];
      e1 = int'(s1 & 16'h0FFF);
      e2 = int'(s2 & 16'h0FFF);
      isLast = ctl[29] ? 1 : 0;
      anom = (e1 > 2048 || e2 != 0) ? 1 : 0;
      nxt = ctl[21] ? 0 : 32;
      clearAll();
      loadBase(32'h0);
      putDesc(0, ctl, {s2, s1}, a);
      pulsePoll(1);
      waitIdle();
      check(xferCnt == 1, "R3 one transfer", xferCnt, 1);
      check(lastLen == e1 + e2, "R3 length", lastLen, e1 + e2);
      check(lastAddr == int'(a), "R3 buffer address", lastAddr, int'(a));
      check(lastFlag == isLast, "R4 last flag", lastFlag, isLast);
      check(frameCnt == isLast, "R4 frame pulse", frameCnt, isLast);
      check(errCnt == anom, "R7 anomaly pulse", errCnt, anom);
      check(mem[0] == (ctl & ~OWN), "R5 write-back", int'(mem[0]), int'(ctl & ~OWN));
      check(nLog == 2 && ctlLog[1] == nxt, "R6 next pointer", ctlLog[1], nxt);
    end

    // R3/R6: chained segments with wrap on a non-zero base
    clearAll();
    loadBase(32'h40);
    putDesc(32'h40, OWN, 32'd20, 32'h7000);
    putDesc(32'h60, OWN, 32'd30, 32'h7100);
    putDesc(32'h80, OWN | LAST | WRAP, 32'd40, 32'h7200);
    pulsePoll(1);
    waitIdle();
    check(xferCnt == 3, "R3 chain transfers", xferCnt, 3);
    check(frameCnt == 1, "R4 one frame for chain", frameCnt, 1);
    check(lastLen == 40 && lastAddr == 32'h7200, "R3 final segment", lastLen, 40);
    check(nLog == 4, "R6 chain reads", nLog, 4);
    check(ctlLog[1] == 32'h60 && ctlLog[2] == 32'h80, "R6 advance by 32", ctlLog[2], 32'h80);
    check(ctlLog[3] == 32'h40, "R6 wrap to base", ctlLog[3], 32'h40);
    check(mem[16] == 32'h0 && mem[32] == (LAST | WRAP), "R5 chain write-back", int'(mem[32]), int'(LAST | WRAP));

    // R9: two polls during a scan give one more scan
    clearAll();
    loadBase(32'h0);
    putDesc(0, OWN | LAST, 32'd8, 32'h8000);
    pulsePoll(1);
    pulsePoll(0);
    pulsePoll(0);
    waitIdle();
    check(nLog == 3, "R9 one extra scan", nLog, 3);
    check(ctlLog[2] == 32'h20, "R9 extra scan address", ctlLog[2], 32'h20);
    check(xferCnt == 1, "R9 single transfer", xferCnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule